// File: doc/BRIEF.md
# Asynchronous Event Gate

This block collects asynchronous event requests for a processor core and decides, once per pipeline cycle, whether one of them becomes a trap. Three reset-class sources (power-on style cold reset, warm soft reset and a non-maskable interrupt) are caught on their rising edge and held in a pending-event vector until they are serviced. A set of maskable interrupt lines is also registered into that vector. Their pending bits are level-driven: each one follows its line with a single cycle of delay.

On every cycle in which the pipeline raises its cycle strobe, the gate looks at the pending vector as it stood at the start of that cycle. Any pending reset-class event wins, and only the most urgent one is taken and cleared. If no reset-class event is pending, an interrupt is taken only when the status fields permit it: interrupts enabled, not at exception level and not at error level. At least one pending interrupt bit must also meet a set bit in the interrupt mask.

The decision is held in a five-state machine. `ST_IDLE` means nothing was taken. `ST_COLD`, `ST_SOFT` and `ST_NMI` each drive a one-cycle reset-take pulse carrying their cause code. `ST_IRQ` drives a one-cycle interrupt-take pulse. On each clock edge the machine takes one of the following transitions. *take-cold*, *take-soft* and *take-nmi* are chosen by reset-class priority when the strobe is high. *take-irq* is chosen when the strobe is high, no reset-class event is pending and the interrupt gate is open. *settle* returns to `ST_IDLE` when there is no strobe or nothing qualifies. Every state leaves after exactly one cycle.

Top module: `event_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending vector is cleared. After that edge `rst_take` and `irq_take` are low and `pend_vec` reads zero.
- R2: A rising edge of a reset-class request sets its pending bit at the next clock edge. Cold reset uses bit 0, soft reset bit 1 and NMI bit 2. The bit stays set until that event is taken, and a request line held high after the take does not set it again.
- R3: Pending bit `8+i` equals the value of `irq_req[i]` at the previous clock edge.
- R4: At an edge where `cyc_stb` is high and any of `pend_vec[7:0]` is set, `rst_take` is high for the following cycle and `irq_take` is low.
- R5: Among pending reset-class bits, cold reset outranks soft reset and soft reset outranks NMI. `rst_cause` reads 1 for cold, 2 for soft and 3 for NMI while `rst_take` is high, and 0 otherwise.
- R6: Only the taken reset-class bit is cleared, at the same edge that raises `rst_take`. A rising edge arriving at that same edge sets the bit again.
- R7: At an edge where `cyc_stb` is high and no reset-class bit is pending, `irq_take` is high for the following cycle exactly when all of these hold: `sr_ie` is 1, `sr_exl` is 0, `sr_erl` is 0, and `pend_vec[8 +: NUM_IRQ] & sr_im` is nonzero.
- R8: After an edge with `cyc_stb` low, both take outputs are low, whatever is pending.
- R9: When no pending bit is set, both take outputs stay low.
- R10: Bits 3 to 7 of `pend_vec` always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_stb | input | 1 | Pipeline cycle strobe; a decision is made at edges where it is high |
| cold_rst_req | input | 1 | Cold reset request, edge-captured |
| soft_rst_req | input | 1 | Soft reset request, edge-captured |
| nmi_req | input | 1 | Non-maskable interrupt request, edge-captured |
| irq_req | input | NUM_IRQ | Maskable interrupt lines, level-driven |
| sr_ie | input | 1 | Status: interrupt enable |
| sr_exl | input | 1 | Status: exception level |
| sr_erl | input | 1 | Status: error level |
| sr_im | input | NUM_IRQ | Status: interrupt mask, aligned to `pend_vec[8 +: NUM_IRQ]` |
| rst_take | output | 1 | One-cycle reset-class trap pulse |
| rst_cause | output | 2 | Cause of the reset-class trap: 1 cold, 2 soft, 3 NMI |
| irq_take | output | 1 | One-cycle interrupt trap pulse |
| pend_vec | output | 8+NUM_IRQ | Pending-event vector |

## Verification
The assertions check three things on every cycle. A take pulse must follow a strobe. A cold cause must come from a pending cold bit, and a soft cause must not be taken over a pending cold bit. An interrupt take must follow open status gates and an empty reset-class byte. Some behaviour can only be shown by the bench's scenarios. These are edge capture that does not retrigger on a held line, clearing of only the serviced bit, the ordered drain of three simultaneous reset-class events, and the exact cycle in which each interrupt line reaches the vector. The bench compares every cycle against its own model under random traffic.

// File: rtl/event_gate_pkg.sv
package event_gate_pkg;

    localparam int RST_BYTE_W = 8;
    localparam int COLD_BIT   = 0;
    localparam int SOFT_BIT   = 1;
    localparam int NMI_BIT    = 2;
    localparam int RC_USED    = 3;

    localparam logic [1:0] CAUSE_NONE = 2'd0;
    localparam logic [1:0] CAUSE_COLD = 2'd1;
    localparam logic [1:0] CAUSE_SOFT = 2'd2;
    localparam logic [1:0] CAUSE_NMI  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_COLD = 3'd1,
        ST_SOFT = 3'd2,
        ST_NMI  = 3'd3,
        ST_IRQ  = 3'd4
    } gate_state_e;

endpackage

// File: rtl/event_gate_pending.sv
module event_gate_pending
    import event_gate_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    localparam int EV_W   = RST_BYTE_W + NUM_IRQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RC_USED-1:0] rc_req,
    input  logic [RC_USED-1:0] rc_clr,
    input  logic [NUM_IRQ-1:0] irq_req,
    output logic [EV_W-1:0]    pend
);

    logic [RC_USED-1:0] req_q;
    logic [RC_USED-1:0] rc_q;
    logic [NUM_IRQ-1:0] irq_q;

    // One capture flop per reset-class source: rising edge sets, take clears
    for (genvar g = 0; g < RC_USED; g++) begin : g_rc
        logic rise;
        assign rise = rc_req[g] & ~req_q[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[g] <= 1'b0;
                rc_q[g]  <= 1'b0;
            end else begin
                req_q[g] <= rc_req[g];
                rc_q[g]  <= (rc_q[g] & ~rc_clr[g]) | rise;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_req;
        end
    end

    always_comb begin
        pend                      = '0;
        pend[RC_USED-1:0]         = rc_q;
        pend[RST_BYTE_W +: NUM_IRQ] = irq_q;
    end

endmodule

// File: rtl/event_gate_arbiter.sv
module event_gate_arbiter
    import event_gate_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    localparam int EV_W   = RST_BYTE_W + NUM_IRQ
) (
    input  logic [EV_W-1:0]    pend,
    input  logic               stb,
    input  logic               ie,
    input  logic               exl,
    input  logic               erl,
    input  logic [NUM_IRQ-1:0] im,
    output gate_state_e        next_state,
    output logic [RC_USED-1:0] rc_clr
);

    logic rc_any;
    logic irq_gate_open;
    logic irq_hit;

    assign rc_any        = |pend[RST_BYTE_W-1:0];
    assign irq_gate_open = ie & ~exl & ~erl;
    assign irq_hit       = |(pend[RST_BYTE_W +: NUM_IRQ] & im);

    always_comb begin
        next_state = ST_IDLE;
        rc_clr     = '0;
        if (stb) begin
            if (pend[COLD_BIT]) begin
                next_state       = ST_COLD;
                rc_clr[COLD_BIT] = 1'b1;
            end else if (pend[SOFT_BIT]) begin
                next_state       = ST_SOFT;
                rc_clr[SOFT_BIT] = 1'b1;
            end else if (pend[NMI_BIT]) begin
                next_state       = ST_NMI;
                rc_clr[NMI_BIT]  = 1'b1;
            end else if (!rc_any && irq_gate_open && irq_hit) begin
                next_state       = ST_IRQ;
            end
        end
    end

endmodule

// File: rtl/event_gate_fsm.sv
module event_gate_fsm
    import event_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  gate_state_e next_state,
    output logic        rst_take,
    output logic [1:0]  rst_cause,
    output logic        irq_take
);

    gate_state_e state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= next_state;
        end
    end

    always_comb begin
        rst_take  = 1'b0;
        rst_cause = CAUSE_NONE;
        irq_take  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_COLD: begin
                rst_take  = 1'b1;
                rst_cause = CAUSE_COLD;
            end
            ST_SOFT: begin
                rst_take  = 1'b1;
                rst_cause = CAUSE_SOFT;
            end
            ST_NMI: begin
                rst_take  = 1'b1;
                rst_cause = CAUSE_NMI;
            end
            ST_IRQ:  irq_take = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/event_gate.sv
module event_gate
    import event_gate_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    localparam int EV_W   = RST_BYTE_W + NUM_IRQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_stb,
    input  logic               cold_rst_req,
    input  logic               soft_rst_req,
    input  logic               nmi_req,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               sr_ie,
    input  logic               sr_exl,
    input  logic               sr_erl,
    input  logic [NUM_IRQ-1:0] sr_im,
    output logic               rst_take,
    output logic [1:0]         rst_cause,
    output logic               irq_take,
    output logic [EV_W-1:0]    pend_vec
);

    logic [RC_USED-1:0] rc_req;
    logic [RC_USED-1:0] rc_clr;
    gate_state_e        next_state;

    always_comb begin
        rc_req           = '0;
        rc_req[COLD_BIT] = cold_rst_req;
        rc_req[SOFT_BIT] = soft_rst_req;
        rc_req[NMI_BIT]  = nmi_req;
    end

    event_gate_pending #(.NUM_IRQ(NUM_IRQ)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .rc_req  (rc_req),
        .rc_clr  (rc_clr),
        .irq_req (irq_req),
        .pend    (pend_vec)
    );

    event_gate_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arbiter (
        .pend       (pend_vec),
        .stb        (cyc_stb),
        .ie         (sr_ie),
        .exl        (sr_exl),
        .erl        (sr_erl),
        .im         (sr_im),
        .next_state (next_state),
        .rc_clr     (rc_clr)
    );

    event_gate_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_state (next_state),
        .rst_take   (rst_take),
        .rst_cause  (rst_cause),
        .irq_take   (irq_take)
    );

    AST_TAKE_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_take || irq_take) |-> $past(cyc_stb)); // R8

    AST_COLD_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_take && rst_cause == CAUSE_COLD) |-> $past(pend_vec[COLD_BIT])); // R5

    AST_SOFT_BELOW_COLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_take && rst_cause == CAUSE_SOFT) |-> !$past(pend_vec[COLD_BIT])); // R5

    AST_IRQ_GATES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(sr_ie && !sr_exl && !sr_erl)); // R7

    AST_IRQ_NO_RST_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ($past(pend_vec[RST_BYTE_W-1:0]) == '0)); // R4

endmodule

// File: tb/event_gate_tb.sv
module event_gate_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int EV_W       = 8 + N;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cyc_stb;
    logic         cold_rst_req, soft_rst_req, nmi_req;
    logic [N-1:0] irq_req;
    logic         sr_ie, sr_exl, sr_erl;
    logic [N-1:0] sr_im;
    logic         rst_take;
    logic [1:0]   rst_cause;
    logic         irq_take;
    logic [EV_W-1:0] pend_vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench model
    logic [2:0]   m_rc, m_reqq;
    logic [N-1:0] m_irq;
    logic         e_rst, e_irq;
    logic [1:0]   e_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    event_gate #(.NUM_IRQ(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb),
        .cold_rst_req(cold_rst_req), .soft_rst_req(soft_rst_req), .nmi_req(nmi_req),
        .irq_req(irq_req), .sr_ie(sr_ie), .sr_exl(sr_exl), .sr_erl(sr_erl), .sr_im(sr_im),
        .rst_take(rst_take), .rst_cause(rst_cause), .irq_take(irq_take), .pend_vec(pend_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [EV_W-1:0] exp_pend();
        logic [EV_W-1:0] v = '0;
        v[2:0]   = m_rc;
        v[8 +: N] = m_irq;
        return v;
    endfunction

    task automatic model_edge();
        logic [2:0] clr  = 3'b0;
        logic [2:0] req  = {nmi_req, soft_rst_req, cold_rst_req};
        logic [2:0] rise;
        e_rst = 1'b0; e_irq = 1'b0; e_cause = 2'd0;
        if (!rst_n) begin
            m_rc = '0; m_reqq = '0; m_irq = '0;
        end else begin
            if (cyc_stb) begin
                if (m_rc[0])      begin e_rst = 1'b1; e_cause = 2'd1; clr = 3'b001; end
                else if (m_rc[1]) begin e_rst = 1'b1; e_cause = 2'd2; clr = 3'b010; end
                else if (m_rc[2]) begin e_rst = 1'b1; e_cause = 2'd3; clr = 3'b100; end
                else if (sr_ie && !sr_exl && !sr_erl && ((m_irq & sr_im) != '0))
                    e_irq = 1'b1;
            end
            rise   = req & ~m_reqq;
            m_rc   = (m_rc & ~clr) | rise;
            m_reqq = req;
            m_irq  = irq_req;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R4 rst_take",  {31'b0, rst_take}, {31'b0, e_rst});
        chk("R5 rst_cause", {30'b0, rst_cause}, {30'b0, e_cause});
        chk("R7 irq_take",  {31'b0, irq_take}, {31'b0, e_irq});
        chk("R2/R6 pend reset-class", {29'b0, pend_vec[2:0]}, {29'b0, m_rc});
        chk("R3 pend irq", {24'b0, pend_vec[8 +: N]}, {24'b0, m_irq});
        chk("R10 reserved", {27'b0, pend_vec[7:3]}, 32'b0);
    endtask

    task automatic idle_inputs();
        cyc_stb = 1'b0; cold_rst_req = 1'b0; soft_rst_req = 1'b0; nmi_req = 1'b0;
        irq_req = '0; sr_ie = 1'b1; sr_exl = 1'b0; sr_erl = 1'b0; sr_im = '1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        rst_n = 1'b0;
        m_rc = '0; m_reqq = '0; m_irq = '0;
        irq_req = 8'hFF; cold_rst_req = 1'b1;
        step(); step();
        // R1: reset state
        chk("R1 pend after reset", {16'b0, pend_vec}, 32'b0);
        chk("R1 takes after reset", {30'b0, rst_take, irq_take}, 32'b0);
        idle_inputs();
        rst_n = 1'b1;
        step();

        // R9: nothing pending, strobes give nothing
        cyc_stb = 1'b1;
        step(); step();
        chk("R9 no take when empty", {30'b0, rst_take, irq_take}, 32'b0);

        // R5/R6: all three reset-class at once, drained in priority order
        cyc_stb = 1'b0;
        cold_rst_req = 1'b1; soft_rst_req = 1'b1; nmi_req = 1'b1;
        step();
        // R8: no strobe, pending remains, no take
        step();
        chk("R8 held without strobe", {29'b0, pend_vec[2:0]}, 32'd7);
        cyc_stb = 1'b1;
        step(); chk("R5 first cold", {30'b0, rst_cause}, 32'd1);
        step(); chk("R5 then soft", {30'b0, rst_cause}, 32'd2);
        step(); chk("R5 then nmi", {30'b0, rst_cause}, 32'd3);
        // R2: held lines do not retrigger
        step(); chk("R2 no retrigger", {29'b0, pend_vec[2:0]}, 32'd0);
        cold_rst_req = 1'b0; soft_rst_req = 1'b0; nmi_req = 1'b0;
        step();

        // R7: interrupts gated by status
        irq_req = 8'h10; sr_im = 8'h10; sr_exl = 1'b1;
        step(); step();
        chk("R7 blocked by exl", {31'b0, irq_take}, 32'd0);
        sr_exl = 1'b0; sr_erl = 1'b1;
        step(); chk("R7 blocked by erl", {31'b0, irq_take}, 32'd0);
        sr_erl = 1'b0; sr_im = 8'h01;
        step(); chk("R7 blocked by mask", {31'b0, irq_take}, 32'd0);
        sr_im = 8'h30;
        step(); chk("R7 taken", {31'b0, irq_take}, 32'd1);
        // R4: reset-class beats interrupt
        nmi_req = 1'b1;
        step(); step();
        chk("R4 nmi over irq", {30'b0, rst_take, irq_take}, 32'd2);
        nmi_req = 1'b0;
        step();

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            cyc_stb = ($urandom % 3) != 0;
            irq_req = 8'($urandom) & 8'($urandom);
            sr_im   = 8'($urandom);
            sr_ie   = ($urandom % 4) != 0;
            sr_exl  = ($urandom % 8) == 0;
            sr_erl  = ($urandom % 8) == 0;
            if (($urandom % 20) == 0) cold_rst_req = ~cold_rst_req;
            if (($urandom % 15) == 0) soft_rst_req = ~soft_rst_req;
            if (($urandom % 10) == 0) nmi_req      = ~nmi_req;
            if (($urandom % 500) == 0) rst_n = 1'b0; else rst_n = 1'b1;
            step();
        end
        finish_run();
    end

endmodule